// File: doc/BRIEF.md
# Scaled Shift-Add Address Unit

This unit produces 64-bit integer results for a small family of shift-and-add operations. These are used both as plain arithmetic and as effective-address generation. One operation shifts a register left by a small amount and adds a second register. The other three add a base register to an immediate that has been scaled and sign-extended in a form fixed by the operation: a pointer-style offset in units of 4 bytes, a high immediate placed at bits 31:16, and a broadcast-load offset whose scale follows the element size.

The caller presents an operation select, a 2-bit mode, two 64-bit operands and a raw 16-bit immediate field, together with a valid strobe. The result appears registered one clock later. The unit also splits a 32-bit shift-add instruction word into its fields, combinationally. It reports the applied shift, which is one more than the encoded field. The unit performs no memory access.

Top module: `scaled_addr_unit`

## Requirements
- R1: While reset is held and after its release, out_valid is 0 and result is 0 until the first accepted input.
- R2: out_valid equals in_valid delayed by one clock. result changes only in the cycle after in_valid was 1, and it holds its value otherwise.
- R3: With op=0 (shift-add) and mode 0 or 3, result = (opa << (imm[1:0]+1)) + opb, so the applied shift is 1 to 4.
- R4: With op=0 and mode 1, the shift-add sum is cut to its low 32 bits and sign-extended to 64.
- R5: With op=0 and mode 2, the shift-add sum is cut to its low 32 bits and zero-extended to 64.
- R6: With op=1 (pointer address), result = opa + sign-extend(imm[13:0] << 2).
- R7: With op=2 (high add), result = opa + sign-extend(imm[15:0] << 16).
- R8: With op=3 (broadcast address), mode selects the element size. Mode 0 adds sign-extended imm[11:0], mode 1 adds imm[10:0]<<1, mode 2 adds imm[9:0]<<2 and mode 3 adds imm[8:0]<<3, each sign-extended from 12 bits.
- R9: All sums wrap modulo 2^64.
- R10: Decode splits insn_word into opcode bits 31:17, shift field 16:15, rk 14:10, rj 9:5 and rd 4:0, and dec_shamt is the shift field plus one. For example, 0x002d9486 gives shift 4, rk 5, rj 4 and rd 6.
- R11: Immediate bits above the field that an operation uses have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid this cycle |
| op | input | 2 | 0 shift-add, 1 pointer address, 2 high add, 3 broadcast address |
| mode | input | 2 | Width mode (shift-add) or element size (broadcast) |
| opa | input | 64 | Shifted operand or base register |
| opb | input | 64 | Addend register for shift-add |
| imm | input | 16 | Raw immediate field |
| insn_word | input | 32 | Shift-add instruction word to decode |
| out_valid | output | 1 | result holds a new value |
| result | output | 64 | Registered result |
| dec_opcode | output | 15 | Decoded opcode field |
| dec_shamt | output | 3 | Applied shift (field + 1) |
| dec_rk | output | 5 | Decoded rk |
| dec_rj | output | 5 | Decoded rj |
| dec_rd | output | 5 | Decoded rd |

## Verification
Shift-add is tried at every encoded shift value, so an off-by-one in the shift bias shows up directly. It is also tried with sums whose bit 31 is set in both word modes, which separates sign extension from zero extension. Each offset form is given both positive and negative immediates at its field edge, and junk in the unused upper immediate bits, so that the wrong pre-scale, the wrong field width or a missed sign bit each gives a distinct value. Base values near 2^64 show the wraparound. The reference instruction word checks the bit positions of the decode.

// File: rtl/sau_pkg.sv
package sau_pkg;
  localparam int XLEN  = 64;
  localparam int IMM_W = 16;
  localparam int HALF  = XLEN / 2;

  typedef enum logic [1:0] {
    OP_SHADD = 2'd0,
    OP_PTR   = 2'd1,
    OP_HIADD = 2'd2,
    OP_BCAST = 2'd3
  } sau_op_e;

  typedef enum logic [1:0] {
    WM_FULL  = 2'd0,
    WM_WSIGN = 2'd1,
    WM_WZERO = 2'd2,
    WM_FULL2 = 2'd3
  } sau_wmode_e;

  // Shift-add: applied shift is the encoded field plus one.
  function automatic logic [XLEN-1:0] shadd_fn(input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b,
                                              input logic [1:0] sa2,
                                              input logic [1:0] wm);
    logic [XLEN-1:0] sum;
    logic [2:0]      amt;
    amt = {1'b0, sa2} + 3'd1;
    sum = (a << amt) + b;
    case (wm)
      WM_WSIGN: shadd_fn = {{HALF{sum[HALF-1]}}, sum[HALF-1:0]};
      WM_WZERO: shadd_fn = {{HALF{1'b0}}, sum[HALF-1:0]};
      default:  shadd_fn = sum;
    endcase
  endfunction

  // Sign-extend a 12-bit scaled broadcast offset.
  function automatic logic [XLEN-1:0] sext12(input logic [11:0] v);
    sext12 = {{(XLEN-12){v[11]}}, v};
  endfunction
endpackage

// File: rtl/sau_decode.sv
module sau_decode (
  input  logic [31:0] word,
  output logic [14:0] opcode,
  output logic [2:0]  shamt,
  output logic [4:0]  rk,
  output logic [4:0]  rj,
  output logic [4:0]  rd
);
  logic [1:0] sa_field;

  always_comb begin
    opcode   = word[31:17];
    sa_field = word[16:15];
    rk       = word[14:10];
    rj       = word[9:5];
    rd       = word[4:0];
    shamt    = {1'b0, sa_field} + 3'd1;
  end
endmodule

// File: rtl/sau_offset.sv
module sau_offset
  import sau_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int NSIZE = 4
) (
  input  logic [1:0]       op,
  input  logic [1:0]       esize,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     offset
);
  logic [W-1:0] bcast_cand [NSIZE];
  logic [W-1:0] ptr_off;
  logic [W-1:0] hi_off;

  // One candidate per element size: field of 12-g bits shifted by g.
  for (genvar g = 0; g < NSIZE; g++) begin : g_scale
    logic [11:0] scaled;
    assign scaled        = imm[11:0] << g;
    assign bcast_cand[g] = sext12(scaled);
  end

  assign ptr_off = {{(W-16){imm[13]}}, imm[13:0], 2'b00};
  assign hi_off  = {{(W-32){imm[15]}}, imm[15:0], 16'h0000};

  always_comb begin
    case (op)
      OP_PTR:   offset = ptr_off;
      OP_HIADD: offset = hi_off;
      OP_BCAST: offset = bcast_cand[esize];
      default:  offset = '0;
    endcase
  end
endmodule

// File: rtl/sau_shadd.sv
module sau_shadd
  import sau_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sa2,
  input  logic [1:0]   wmode,
  output logic [W-1:0] y
);
  assign y = shadd_fn(a, b, sa2, wmode);
endmodule

// File: rtl/scaled_addr_unit.sv
module scaled_addr_unit
  import sau_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [1:0]        mode,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic [IMM_W-1:0]  imm,
  input  logic [31:0]       insn_word,
  output logic              out_valid,
  output logic [XLEN-1:0]   result,
  output logic [14:0]       dec_opcode,
  output logic [2:0]        dec_shamt,
  output logic [4:0]        dec_rk,
  output logic [4:0]        dec_rj,
  output logic [4:0]        dec_rd
);
  logic [XLEN-1:0] shadd_res;
  logic [XLEN-1:0] scaled_off;
  logic [XLEN-1:0] addr_res;
  logic [XLEN-1:0] next_res;
  logic            is_shadd;

  sau_shadd #(.W(XLEN)) u_shadd (
    .a(opa), .b(opb), .sa2(imm[1:0]), .wmode(mode), .y(shadd_res)
  );

  sau_offset #(.W(XLEN)) u_offset (
    .op(op), .esize(mode), .imm(imm), .offset(scaled_off)
  );

  sau_decode u_decode (
    .word(insn_word), .opcode(dec_opcode), .shamt(dec_shamt),
    .rk(dec_rk), .rj(dec_rj), .rd(dec_rd)
  );

  assign is_shadd = (op == OP_SHADD);
  assign addr_res = opa + scaled_off;
  assign next_res = is_shadd ? shadd_res : addr_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/sau_checker.sv
module sau_checker
  import sau_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      op,
  input logic [1:0]      mode,
  input logic [XLEN-1:0] opa,
  input logic [XLEN-1:0] opb,
  input logic            out_valid,
  input logic [XLEN-1:0] result
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R2
  AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SHADD && mode == WM_WSIGN)
      |=> (result[XLEN-1:HALF] == {HALF{result[HALF-1]}})); // R4
  AST_WORD_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SHADD && mode == WM_WZERO)
      |=> (result[XLEN-1:HALF] == '0)); // R5
  AST_SHADD_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SHADD) |=> (result[0] == $past(opb[0]))); // R3
  AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_PTR) |=> (result[1:0] == $past(opa[1:0]))); // R6
  AST_HI_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_HIADD) |=> (result[15:0] == $past(opa[15:0]))); // R7
endmodule

bind scaled_addr_unit sau_checker u_sau_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .mode(mode),
  .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
);

// File: tb/scaled_addr_unit_bench.sv
`timescale 1ns/1ps
module scaled_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [1:0]  mode = '0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [15:0] imm = '0;
  logic [31:0] insn_word = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [14:0] dec_opcode;
  logic [2:0]  dec_shamt;
  logic [4:0]  dec_rk, dec_rj, dec_rd;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scaled_addr_unit u_scaled_addr_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .mode(mode),
    .opa(opa), .opb(opb), .imm(imm), .insn_word(insn_word),
    .out_valid(out_valid), .result(result), .dec_opcode(dec_opcode),
    .dec_shamt(dec_shamt), .dec_rk(dec_rk), .dec_rj(dec_rj), .dec_rd(dec_rd)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one operation, then sample at the negedge after the capturing edge.
  task automatic run_op(input logic [1:0] o, input logic [1:0] m, input logic [63:0] a,
                        input logic [63:0] b, input logic [15:0] i, output logic [63:0] r);
    @(negedge clk);
    op = o; mode = m; opa = a; opb = b; imm = i; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = result;
  endtask

  function automatic logic [63:0] ref_shadd(logic [63:0] a, logic [63:0] b, int s, int m);
    logic [63:0] p;
    p = a;
    for (int k = 0; k <= s; k++) p = p * 64'd2;
    p = p + b;
    if (m == 1) return 64'($signed(p[31:0]));
    if (m == 2) return {32'd0, p[31:0]};
    return p;
  endfunction

  task automatic t_reset();
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 result", result, 64'd0);
  endtask

  task automatic t_shadd_full();
    logic [63:0] r;
    for (int s = 0; s < 4; s++) begin
      run_op(2'd0, 2'd0, 64'h0123_4567_89ab_cdef, 64'h10, {14'h3fff, 2'(s)}, r);
      check($sformatf("R3 shift field %0d (R11 high bits junk)", s), r,
            ref_shadd(64'h0123_4567_89ab_cdef, 64'h10, s, 0));
    end
    run_op(2'd0, 2'd3, 64'h5, 64'h7, 16'h0002, r);
    check("R3 mode3", r, 64'd47);
    run_op(2'd0, 2'd0, 64'h8000_0000_0000_0001, 64'hffff_ffff_ffff_fffe, 16'h0000, r);
    check("R9 shadd wrap", r, 64'h0);
  endtask

  task automatic t_shadd_word();
    logic [63:0] r;
    run_op(2'd0, 2'd1, 64'h0000_0001_4000_0000, 64'h1, 16'h0000, r);
    check("R4 signed word", r, 64'hffff_ffff_8000_0001);
    run_op(2'd0, 2'd2, 64'h0000_0001_4000_0000, 64'h1, 16'h0000, r);
    check("R5 unsigned word", r, 64'h0000_0000_8000_0001);
    run_op(2'd0, 2'd1, 64'h10, 64'h3, 16'h0001, r);
    check("R4 signed positive", r, 64'h43);
  endtask

  task automatic t_ptr();
    logic [63:0] r;
    run_op(2'd1, 2'd0, 64'h1000, 64'h0, 16'h0002, r);
    check("R6 ptr +8", r, 64'h1008);
    run_op(2'd1, 2'd2, 64'h1000, 64'hdead, 16'hffff, r);
    check("R6 ptr -4 (R11 bits 15:14)", r, 64'h0ffc);
    run_op(2'd1, 2'd0, 64'h1000, 64'h0, 16'h2000, r);
    check("R6 ptr min", r, 64'h1000 - 64'd32768);
  endtask

  task automatic t_hiadd();
    logic [63:0] r;
    run_op(2'd2, 2'd0, 64'h1234, 64'h0, 16'h0001, r);
    check("R7 hi +1", r, 64'h0001_1234);
    run_op(2'd2, 2'd1, 64'h0, 64'h0, 16'h8000, r);
    check("R7 hi negative", r, 64'hffff_ffff_8000_0000);
    run_op(2'd2, 2'd0, 64'hffff_ffff_ffff_0000, 64'h0, 16'h0001, r);
    check("R9 hi wrap", r, 64'h0);
  endtask

  task automatic t_bcast();
    logic [63:0] r;
    run_op(2'd3, 2'd0, 64'h100, 64'h0, 16'hf001, r);
    check("R8 byte +1 (R11)", r, 64'h101);
    run_op(2'd3, 2'd1, 64'h100, 64'h0, 16'h0001, r);
    check("R8 half +2", r, 64'h102);
    run_op(2'd3, 2'd2, 64'h100, 64'h0, 16'h0002, r);
    check("R8 word +8", r, 64'h108);
    run_op(2'd3, 2'd3, 64'h100, 64'h0, 16'h0001, r);
    check("R8 dword +8", r, 64'h108);
    run_op(2'd3, 2'd1, 64'h1000, 64'h0, 16'h0400, r);
    check("R8 half min", r, 64'h1000 - 64'd2048);
    run_op(2'd3, 2'd3, 64'h1000, 64'h0, 16'h0f00, r);
    check("R8 dword min (R11 bits 11:9)", r, 64'h1000 - 64'd2048);
  endtask

  task automatic t_hold();
    logic [63:0] r;
    run_op(2'd1, 2'd0, 64'h40, 64'h0, 16'h0001, r);
    check("R2 valid after op", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    opa = 64'hffff; imm = 16'h7777;
    @(negedge clk);
    check("R2 valid drops", {63'd0, out_valid}, 64'd0);
    check("R2 result holds", result, 64'h44);
  endtask

  task automatic t_decode();
    insn_word = 32'h002d9486;
    #1;
    check("R10 shamt", {61'd0, dec_shamt}, 64'd4);
    check("R10 rk", {59'd0, dec_rk}, 64'd5);
    check("R10 rj", {59'd0, dec_rj}, 64'd4);
    check("R10 rd", {59'd0, dec_rd}, 64'd6);
    check("R10 opcode", {49'd0, dec_opcode}, 64'h16);
    insn_word = 32'hfffe_0000;
    #1;
    check("R10 min shamt", {61'd0, dec_shamt}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadd_full();
    t_shadd_word();
    t_ptr();
    t_hiadd();
    t_bcast();
    t_hold();
    t_decode();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule